// File: doc/BRIEF.md
# Dual-Port Token Flag Unit

This block holds eight token flags that two processors, one on a left port and one on a right port, use to share resources without hardware wait states. To claim a flag, a port writes a zero to it and then reads it back. A read of all zeros means the port holds the token. A read of all ones means the other side holds it. A port returns a token by writing a one. A request that arrives while the other side holds the flag is not lost. It stays pending, and the token moves to that side as soon as the owner releases it.

Each port has its own request latch for every flag, and per-flag logic decides which side owns the token. Each port also has a read holding register, so a value being read cannot change during the read because of activity on the other port. The whole block runs on one clock and has a synchronous active-low reset. All port controls are active high.

Top module: `dp_token_flags`

## Requirements
- R1: After reset, every request latch holds one and no flag has an owner, so any read on either port returns 8'hFF.
- R2: A write takes effect only at a clock edge where the port's select and write strobe are both high. It acts on the flag addressed by the 3-bit index and uses only the single write data bit. A write strobe without select changes nothing.
- R3: Writing zero to a free flag makes the writer the owner. The owner then reads 8'h00 and the other port reads 8'hFF. A flag never has two owners.
- R4: When the non-owner writes zero, its request is stored as pending. The owner keeps the token for as long as it does not write one.
- R5: When the owner writes one while the other side has a request pending, the other side owns the flag from the next cycle. It keeps ownership until it writes one itself.
- R6: When the owner writes one and no request is pending on the other side, the flag becomes free and both ports read 8'hFF.
- R7: A read returns the flag as that port sees it, copied to all eight bits. The value is 8'h00 when that port owns the flag and 8'hFF otherwise.
- R8: The read value is taken in the first cycle in which select and output enable are both high. It stays unchanged until one of the two goes low, even if ownership changes in the meantime.
- R9: A port's read data is 8'h00 whenever its select or its output enable is low.
- R10: When both ports write zero to the same free flag in the same cycle, the left port becomes the owner and the right port's request becomes pending.
- R11: When the non-owner writes one, its pending request is withdrawn. A later release by the owner then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel | input | 1 | Left port flag select |
| l_oe | input | 1 | Left port output enable |
| l_we | input | 1 | Left port write strobe |
| l_idx | input | 3 | Left port flag index |
| l_wdata | input | 1 | Left port write bit (0 requests, 1 releases) |
| l_rdata | output | 8 | Left port read data |
| r_sel | input | 1 | Right port flag select |
| r_oe | input | 1 | Right port output enable |
| r_we | input | 1 | Right port write strobe |
| r_idx | input | 3 | Right port flag index |
| r_wdata | input | 1 | Right port write bit (0 requests, 1 releases) |
| r_rdata | output | 8 | Right port read data |

## Verification
A wrong owner bit or a lost request latch shows up on the first fresh read of that flag after the faulty update. In a fault-free design, that read takes place one clock after the write that caused the update. Such a fault appears as 8'h00 and 8'hFF swapped between the two ports, or as both ports reading 8'hFF while a handoff was due. A fault in the holding register appears in the middle of a read, as data that changes while select and output enable stay high. A fault in the idle gating appears as nonzero data on an idle port. The bench steps every flag through claim, pending, handoff, withdrawal, tie and held-read sequences. It then runs a long random mix of operations against a model that predicts both read ports in every cycle.

// File: rtl/dp_token_flags.sv
module dp_token_flags #(
  parameter int FLAGS = 8,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       l_sel,
  input  logic                       l_oe,
  input  logic                       l_we,
  input  logic [$clog2(FLAGS)-1:0]   l_idx,
  input  logic                       l_wdata,
  output logic [DW-1:0]              l_rdata,
  input  logic                       r_sel,
  input  logic                       r_oe,
  input  logic                       r_we,
  input  logic [$clog2(FLAGS)-1:0]   r_idx,
  input  logic                       r_wdata,
  output logic [DW-1:0]              r_rdata
);
  localparam int IW = $clog2(FLAGS);

  logic [FLAGS-1:0] lreq_n, rreq_n, lown, rown, l_hit, r_hit;

  wire l_wr = l_sel & l_we;
  wire r_wr = r_sel & r_we;

  for (genvar i = 0; i < FLAGS; i++) begin : g_flag
    logic lq, rq, lo, ro;
    wire nl = l_hit[i] ? l_wdata : lq;
    wire nr = r_hit[i] ? r_wdata : rq;

    assign l_hit[i]  = l_wr && (l_idx == IW'(i));
    assign r_hit[i]  = r_wr && (r_idx == IW'(i));
    assign lreq_n[i] = lq;
    assign rreq_n[i] = rq;
    assign lown[i]   = lo;
    assign rown[i]   = ro;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lq <= 1'b1;
        rq <= 1'b1;
        lo <= 1'b0;
        ro <= 1'b0;
      end else begin
        lq <= nl;
        rq <= nr;
        if (lo) begin
          if (nl) begin
            lo <= 1'b0;
            ro <= !nr;
          end
        end else if (ro) begin
          if (nr) begin
            ro <= 1'b0;
            lo <= !nl;
          end
        end else begin
          lo <= !nl;
          ro <= nl && !nr;
        end
      end
    end

    a_r4_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      lo && !(l_hit[i] && l_wdata) |=> lo);
    a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      lo && l_hit[i] && l_wdata && !rq && !r_hit[i] |=> ro);
    a_r6_free_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      lo && l_hit[i] && l_wdata && rq && !r_hit[i] |=> !lo && !ro);
    a_r10_left_tie: assert property (@(posedge clk) disable iff (!rst_n)
      !lo && !ro && l_hit[i] && !l_wdata && r_hit[i] && !r_wdata |=> lo && !rq);
  end

  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (lown & rown) == '0);

  wire l_rd = l_sel & l_oe;
  wire r_rd = r_sel & r_oe;
  wire l_view = ~lown[l_idx];
  wire r_view = ~rown[r_idx];
  logic l_act, r_act;
  logic [DW-1:0] l_hold, r_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_act  <= 1'b0;
      r_act  <= 1'b0;
      l_hold <= '0;
      r_hold <= '0;
    end else begin
      l_act <= l_rd;
      r_act <= r_rd;
      if (l_rd && !l_act) l_hold <= {DW{l_view}};
      if (r_rd && !r_act) r_hold <= {DW{r_view}};
    end
  end

  assign l_rdata = !l_rd ? '0 : (l_act ? l_hold : {DW{l_view}});
  assign r_rdata = !r_rd ? '0 : (r_act ? r_hold : {DW{r_view}});

  a_r8_left_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd && l_act |-> l_rdata == $past(l_rdata));
  a_r8_right_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd && r_act |-> r_rdata == $past(r_rdata));
endmodule

// File: tb/dp_token_flags_tb_top.sv
module dp_token_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_oe = 0, l_we = 0, l_wdata = 1;
  logic r_sel = 0, r_oe = 0, r_we = 0, r_wdata = 1;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [7:0] l_rdata, r_rdata;
  logic [7:0] gl, gr;
  int checks = 0, fails = 0;

  bit ml_own[8], mr_own[8], ml_req[8], mr_req[8];
  bit ml_act, mr_act;
  logic [7:0] ml_hold, mr_hold;

  always #5 clk = ~clk;

  dp_token_flags dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_oe(l_oe), .l_we(l_we), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_oe(r_oe), .r_we(r_we), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      ml_own[i] = 0; mr_own[i] = 0; ml_req[i] = 1; mr_req[i] = 1;
    end
    ml_act = 0; mr_act = 0; ml_hold = 0; mr_hold = 0;
  endtask

  function automatic logic [7:0] exp_read(bit sel, bit oe, bit act, logic [7:0] hold, bit owns);
    if (!(sel && oe)) return 8'h00;
    if (act) return hold;
    return owns ? 8'h00 : 8'hFF;
  endfunction

  task automatic model_edge();
    bit vl, vr;
    vl = ml_own[l_idx];
    vr = mr_own[r_idx];
    for (int i = 0; i < 8; i++) begin
      bit a, b;
      a = (l_sel && l_we && l_idx == i) ? l_wdata : ml_req[i];
      b = (r_sel && r_we && r_idx == i) ? r_wdata : mr_req[i];
      ml_req[i] = a; mr_req[i] = b;
      if (ml_own[i]) begin
        if (a) begin ml_own[i] = 0; mr_own[i] = !b; end
      end else if (mr_own[i]) begin
        if (b) begin mr_own[i] = 0; ml_own[i] = !a; end
      end else if (!a) ml_own[i] = 1;
      else if (!b) mr_own[i] = 1;
    end
    if (l_sel && l_oe && !ml_act) ml_hold = vl ? 8'h00 : 8'hFF;
    if (r_sel && r_oe && !mr_act) mr_hold = vr ? 8'h00 : 8'hFF;
    ml_act = l_sel && l_oe;
    mr_act = r_sel && r_oe;
  endtask

  task automatic cyc(string tag, bit ls, bit lo, bit lw, int li, bit ld,
                     bit rs, bit ro, bit rw, int ri, bit rd);
    l_sel = ls; l_oe = lo; l_we = lw; l_idx = 3'(li); l_wdata = ld;
    r_sel = rs; r_oe = ro; r_we = rw; r_idx = 3'(ri); r_wdata = rd;
    #1;
    gl = l_rdata; gr = r_rdata;
    chk({tag, " left"}, gl, exp_read(ls, lo, ml_act, ml_hold, ml_own[li]));
    chk({tag, " right"}, gr, exp_read(rs, ro, mr_act, mr_hold, mr_own[ri]));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic lwr(int i, bit d); cyc("R2 lwrite", 1,0,1,i,d, 0,0,0,0,1); endtask
  task automatic rwr(int i, bit d); cyc("R2 rwrite", 0,0,0,0,1, 1,0,1,i,d); endtask
  task automatic rdboth(string tag, int i, logic [7:0] el, logic [7:0] er);
    cyc(tag, 1,1,0,i,1, 1,1,0,i,1);
    chk({tag, " left literal"}, gl, el);
    chk({tag, " right literal"}, gr, er);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) rdboth("R1 reset free", i, 8'hFF, 8'hFF);
    cyc("R9 idle zero", 1,0,0,0,1, 0,1,0,0,1);
    chk("R9 literal left", gl, 8'h00);
    chk("R9 literal right", gr, 8'h00);

    for (int i = 0; i < 8; i++) begin
      lwr(i, 0);
      rdboth("R3 R7 left claim", i, 8'h00, 8'hFF);
      rwr(i, 0);
      rdboth("R4 pending keeps owner", i, 8'h00, 8'hFF);
      lwr(i, 1);
      rdboth("R5 handoff", i, 8'hFF, 8'h00);
      rwr(i, 1);
      rdboth("R6 release free", i, 8'hFF, 8'hFF);
      cyc("R10 tie", 1,0,1,i,0, 1,0,1,i,0);
      rdboth("R10 left wins", i, 8'h00, 8'hFF);
      lwr(i, 1);
      rdboth("R10 R5 loser pending", i, 8'hFF, 8'h00);
      rwr(i, 1);
      lwr(i, 0); rwr(i, 0); rwr(i, 1); lwr(i, 1);
      rdboth("R11 withdrawn", i, 8'hFF, 8'hFF);
      cyc("R2 no select", 0,0,1,i,0, 0,0,1,i,0);
      rdboth("R2 ignored", i, 8'hFF, 8'hFF);
      rwr(i, 0); lwr(i, 0);
      cyc("R8 read start", 1,1,0,i,1, 0,0,0,0,1);
      chk("R8 start literal", gl, 8'hFF);
      cyc("R8 owner releases", 1,1,0,i,1, 1,0,1,i,1);
      cyc("R8 held", 1,1,0,i,1, 0,0,0,0,1);
      chk("R8 held literal", gl, 8'hFF);
      cyc("R8 drop", 1,0,0,i,1, 0,0,0,0,1);
      rdboth("R8 fresh read", i, 8'h00, 8'hFF);
      lwr(i, 1);
    end

    for (int n = 0; n < 4000; n++) begin
      cyc("R7 R8 R9 random", $urandom_range(0,3) != 0, $urandom_range(0,1), $urandom_range(0,1),
          $urandom_range(0,7), $urandom_range(0,1),
          $urandom_range(0,3) != 0, $urandom_range(0,1), $urandom_range(0,1),
          $urandom_range(0,7), $urandom_range(0,1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule